// File: doc/BRIEF.md
# Time-Locked System Configuration Register

This block is an 8-bit configuration register on a simple synchronous microcontroller bus. Software reads and writes it at one fixed bus address. Each stored bit also drives its own output pin, so that other logic can use the setting directly.

Three of the bits can be changed at any time. The other five are guarded, because they hold settings that must not drift once the system is running. In normal operation, the guarded bits accept one write only, and only while a counter started at reset is still below 64. After that first write, or once the counter has run out, they ignore writes.

A special-mode input lifts this restriction. While it is high, the guarded bits accept writes at any time and without any limit on the number of writes.

Top module: `cfgreg_timelock`

## Requirements
- R1: A read with `bus_addr` equal to 16'h0039 returns all eight stored bits on `bus_rdata`, combinationally. Any other address reads as 8'h00. The address decode uses all 16 bits.
- R2: While reset is asserted, and after it, the register holds 8'h10. Bit positions: 7 `adc_pwr_en`, 6 `clk_sel`, 5 `irq_edge`, 4 `osc_delay`, 3 `clkmon_en`, 2 `fast_clkmon_en`, 1:0 `rate_sel`. Each output pin follows its stored bit.
- R3: Bits 7, 6 and 3 are free bits. Every write to 16'h0039 loads them from `bus_wdata`, including a write that is blocked for the guarded bits.
- R4: Bits 5, 4, 2, 1 and 0 are guarded bits. A normal-mode write loads them only if it lands on one of the first 64 rising clock edges after reset is released. The 64th such edge still counts, and the permission must not have been used yet.
- R5: In normal mode, the first write that lands inside the window uses up the permission, even if it writes the values the bits already hold. Later normal-mode writes leave the guarded bits unchanged.
- R6: From the 65th edge after reset release onward, normal-mode writes leave the guarded bits unchanged, however long the part has been running.
- R7: While `spec_mode` is high, a write to 16'h0039 loads the guarded bits at any time and any number of times. Such a write does not use up the normal-mode permission.
- R8: Writes to any other address leave the register and the permission untouched. Reads never affect the permission.
- R9: A new reset restores the permission and restarts the 64-edge window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| spec_mode | input | 1 | Special mode: lifts the guard on the guarded bits |
| adc_pwr_en | output | 1 | Stored bit 7 |
| clk_sel | output | 1 | Stored bit 6 |
| irq_edge | output | 1 | Stored bit 5 |
| osc_delay | output | 1 | Stored bit 4 |
| clkmon_en | output | 1 | Stored bit 3 |
| fast_clkmon_en | output | 1 | Stored bit 2 |
| rate_sel | output | 2 | Stored bits 1:0 |

## Verification
The assertions check several rules on every clock edge:
- the window counter never passes its limit and stays there once it saturates;
- a spent permission stays spent until the next reset;
- blocked or off-address writes leave the guarded bits unchanged;
- every write that hits the address loads the free bits.

Only the bench's scenarios can show where the window edge falls in absolute cycles, namely that the 64th edge accepts a write and the 65th does not. The same holds for the rule that a same-value first write still spends the permission, the rule that special-mode writes leave it unspent, and the rule that a new reset reopens it.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

   // Field layout of the stored byte, MSB first
   typedef struct packed {
      logic       adc_pwr;
      logic       clk_sel;
      logic       irq_edge;
      logic       osc_dly;
      logic       clkmon;
      logic       fast_clkmon;
      logic [1:0] rate;
   } cfg_bits_t;

   localparam int unsigned CFG_W = $bits(cfg_bits_t);

   // Guarded fields: irq_edge, osc_dly, fast_clkmon, rate
   localparam logic [CFG_W-1:0] GUARD_MASK_DEF = 8'b0011_0111;
   localparam logic [CFG_W-1:0] RESET_VAL_DEF  = 8'b0001_0000;

endpackage

// File: rtl/cfg_window_timer.sv
module cfg_window_timer #(
   parameter int unsigned WINDOW = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic in_window
);
   localparam int unsigned CNT_W = (WINDOW < 1) ? 1 : $clog2(WINDOW + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW);

   generate
      if (WINDOW == 0) begin : g_closed
         // No window: the guarded bits are never writable in normal mode
         assign in_window = 1'b0;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (cnt != LIMIT)
               cnt <= cnt + 1'b1;
         end

         assign in_window = (cnt != LIMIT);

         // R6
         cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= LIMIT);
         // R6
         cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == LIMIT) |=> (cnt == LIMIT));
      end
   endgenerate

endmodule

// File: rtl/cfg_write_lock.sv
module cfg_write_lock #(
   parameter bit ONE_SHOT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic in_window,
   input  logic spec_mode,
   output logic guard_we
);
   logic spent;

   generate
      if (ONE_SHOT) begin : g_once
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               spent <= 1'b0;
            else if (wr_hit && in_window && !spec_mode)
               spent <= 1'b1;
         end
         assign guard_we = wr_hit && (spec_mode || (in_window && !spent));
      end else begin : g_multi
         // Variant: any number of writes while the window is open
         assign spent    = 1'b0;
         assign guard_we = wr_hit && (spec_mode || in_window);
      end
   endgenerate

   // R5
   spent_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spent |=> spent);
   // R5
   spent_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spent && !spec_mode) |-> !guard_we);

endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
   parameter int unsigned             DATA_W     = 8,
   parameter logic [DATA_W-1:0]       RESET_VAL  = '0,
   parameter logic [DATA_W-1:0]       GUARD_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              free_we,
   input  logic              guard_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         logic we_i;
         if (GUARD_MASK[i]) begin : g_guard
            assign we_i = guard_we;
         end else begin : g_free
            assign we_i = free_we;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i] <= RESET_VAL[i];
            else if (we_i)
               q[i] <= wdata[i];
         end
      end
   endgenerate

   // R4
   guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !guard_we |=> ((q & GUARD_MASK) == ($past(q) & GUARD_MASK)));

endmodule

// File: rtl/cfgreg_timelock.sv
module cfgreg_timelock
   import cfgreg_pkg::*;
#(
   parameter int unsigned         ADDR_W     = 16,
   parameter int unsigned         DATA_W     = 8,
   parameter logic [ADDR_W-1:0]   REG_ADDR   = 16'h0039,
   parameter int unsigned         WINDOW     = 64,
   parameter bit                  ONE_SHOT   = 1'b1,
   parameter logic [DATA_W-1:0]   RESET_VAL  = RESET_VAL_DEF,
   parameter logic [DATA_W-1:0]   GUARD_MASK = GUARD_MASK_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              spec_mode,
   output logic              adc_pwr_en,
   output logic              clk_sel,
   output logic              irq_edge,
   output logic              osc_delay,
   output logic              clkmon_en,
   output logic              fast_clkmon_en,
   output logic [1:0]        rate_sel
);
   localparam logic [DATA_W-1:0] FREE_MASK = ~GUARD_MASK;

   // Elaboration-time parameter checks
   if (DATA_W != CFG_W) begin : g_bad_width
      $error("cfgreg_timelock: DATA_W must equal the field layout width");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("cfgreg_timelock: ADDR_W must be at least 1");
   end

   logic              hit;
   logic              wr_hit;
   logic              in_window;
   logic              guard_we;
   logic [DATA_W-1:0] q;
   cfg_bits_t         fields;

   assign hit    = (bus_addr == REG_ADDR);
   assign wr_hit = bus_wr && hit;

   cfg_window_timer #(.WINDOW(WINDOW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_window (in_window)
   );

   cfg_write_lock #(.ONE_SHOT(ONE_SHOT)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_hit),
      .in_window (in_window),
      .spec_mode (spec_mode),
      .guard_we  (guard_we)
   );

   cfg_bit_store #(
      .DATA_W     (DATA_W),
      .RESET_VAL  (RESET_VAL),
      .GUARD_MASK (GUARD_MASK)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .free_we  (wr_hit),
      .guard_we (guard_we),
      .wdata    (bus_wdata),
      .q        (q)
   );

   assign bus_rdata = hit ? q : '0;

   assign fields         = cfg_bits_t'(q);
   assign adc_pwr_en     = fields.adc_pwr;
   assign clk_sel        = fields.clk_sel;
   assign irq_edge       = fields.irq_edge;
   assign osc_delay      = fields.osc_dly;
   assign clkmon_en      = fields.clkmon;
   assign fast_clkmon_en = fields.fast_clkmon;
   assign rate_sel       = fields.rate;

   // R3
   free_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit) |=> ((q & FREE_MASK) == ($past(bus_wdata) & FREE_MASK)));
   // R6
   late_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && !spec_mode && !in_window)
         |=> ((q & GUARD_MASK) == ($past(q) & GUARD_MASK)));
   // R8
   off_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit) |=> $stable(q));
   // R7
   spec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && spec_mode)
         |=> ((q & GUARD_MASK) == ($past(bus_wdata) & GUARD_MASK)));

endmodule

// File: tb/sim_cfgreg_timelock.sv
`timescale 1ns/1ps
module sim_cfgreg_timelock;
   localparam logic [15:0] RA = 16'h0039;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = RA;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        spec_mode = 1'b0;
   logic        adc_pwr_en, clk_sel, irq_edge, osc_delay, clkmon_en, fast_clkmon_en;
   logic [1:0]  rate_sel;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   cfgreg_timelock u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spec_mode(spec_mode),
      .adc_pwr_en(adc_pwr_en), .clk_sel(clk_sel), .irq_edge(irq_edge),
      .osc_delay(osc_delay), .clkmon_en(clkmon_en),
      .fast_clkmon_en(fast_clkmon_en), .rate_sel(rate_sel)
   );

   // Vector: {addr, wr, wdata, spec, expected read at RA after the edge}
   localparam int NV = 9;
   localparam logic [33:0] VEC [NV] = '{
      {16'h0039, 1'b0, 8'h00, 1'b0, 8'h10},  // R2 reset value
      {16'h0038, 1'b1, 8'hFF, 1'b0, 8'h10},  // R8 other address
      {16'h0039, 1'b1, 8'h00, 1'b0, 8'h00},  // R4 first write in window
      {16'h0039, 1'b1, 8'hFF, 1'b0, 8'hC8},  // R5 locked, R3 free bits load
      {16'h0039, 1'b1, 8'h37, 1'b0, 8'h00},  // R3 free bits clear, guarded held
      {16'h0039, 1'b1, 8'h37, 1'b1, 8'h37},  // R7 special write
      {16'h0039, 1'b1, 8'h25, 1'b1, 8'h25},  // R7 second special write
      {16'h0039, 1'b1, 8'hFF, 1'b0, 8'hED},  // R5 still locked
      {16'h1039, 1'b1, 8'h00, 1'b0, 8'hED}   // R8 full 16-bit decode
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic step(input logic [15:0] a, input logic w, input logic [7:0] d,
                       input logic s);
      bus_addr = a; bus_wr = w; bus_wdata = d; spec_mode = s;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; spec_mode = 1'b0; bus_addr = RA;
      #1;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(RA, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   function automatic logic [7:0] pins();
      return {adc_pwr_en, clk_sel, irq_edge, osc_delay, clkmon_en, fast_clkmon_en, rate_sel};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   initial begin
      // R2: reset state while reset is held
      @(negedge clk); @(negedge clk);
      check("R2 reset rdata", bus_rdata, 8'h10);
      check("R2 reset pins", pins(), 8'h10);
      rst_n = 1'b1;
      #1;

      // Vector table: first vector lands on the first edge after release
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][33:18], VEC[i][17], VEC[i][16:9], VEC[i][8]);
         check($sformatf("vector %0d", i), bus_rdata, VEC[i][7:0]);
      end
      check("R2 pin mapping", pins(), 8'hED);
      bus_addr = 16'h0100; #1;
      check("R1 off-address read", bus_rdata, 8'h00);
      bus_addr = RA; #1;
      check("R1 register read", bus_rdata, 8'hED);

      // R5: a same-value first write still spends the permission
      do_reset();
      step(RA, 1'b1, 8'h10, 1'b0);
      step(RA, 1'b1, 8'h27, 1'b0);
      check("R5 same-value write spends", bus_rdata, 8'h10);

      // R9: a new reset reopens the permission
      do_reset();
      step(RA, 1'b1, 8'h01, 1'b0);
      check("R9 reset reopens", bus_rdata, 8'h01);

      // R4: the 64th edge (count 63) is still inside the window
      do_reset();
      idle(63);
      step(RA, 1'b1, 8'h03, 1'b0);
      check("R4 last edge in window", bus_rdata, 8'h03);

      // R6: the 65th edge is outside the window; stays closed later
      do_reset();
      idle(64);
      step(RA, 1'b1, 8'h03, 1'b0);
      check("R6 first edge after window", bus_rdata, 8'h10);
      idle(200);
      step(RA, 1'b1, 8'h37, 1'b0);
      check("R6 long after window", bus_rdata, 8'h10);
      step(RA, 1'b1, 8'h07, 1'b1);
      check("R7 special after window", bus_rdata, 8'h07);

      // R7: a special-mode write leaves the permission unspent
      do_reset();
      step(RA, 1'b1, 8'h01, 1'b1);
      check("R7 special in window", bus_rdata, 8'h01);
      step(RA, 1'b1, 8'h02, 1'b0);
      check("R7 permission kept", bus_rdata, 8'h02);
      step(RA, 1'b1, 8'h04, 1'b0);
      check("R5 then locked", bus_rdata, 8'h02);

      // R8: reads and other-address writes leave the permission alone
      do_reset();
      idle(3);
      step(16'h0000, 1'b1, 8'hFF, 1'b0);
      step(16'h0139, 1'b1, 8'hFF, 1'b0);
      check("R8 other address no effect", bus_rdata, 8'h10);
      step(RA, 1'b1, 8'h02, 1'b0);
      check("R8 permission intact", bus_rdata, 8'h02);
      check("R2 pins follow", pins(), 8'h02);

      finish_run();
   end
endmodule